// File: doc/BRIEF.md
# RGB Display Timing Generator

This block drives the synchronisation side of a parallel RGB panel. It counts pixel ticks, given by a clock enable, along each line and counts lines down the frame. From those two counts it forms the horizontal sync, vertical sync and data-enable strobes, the coordinates of the current active pixel, and a request strobe that tells the pixel-data path when to present a pixel. Both axes take their timing as endpoint values stored "minus one". The sync length is the sync width minus one. The front boundary combines sync and back porch, minus one. The visible span and the full period are each stored minus one.

A start pulse launches a frame. With frame repeat enabled, frames follow each other with no gap until a stop pulse arrives. The stop is held until the current frame completes. Each strobe has its own idle level and its own delay of 0 to 3 pixel ticks. The horizontal pulse can begin at any offset within the line. An enable decides whether it also appears on lines outside the visible rows. At the end of the last vertical sync line the block raises a one-cycle interrupt pulse.

Top module: `rgb_timing_gen`

## Requirements
- R1: The line counter advances only on clock cycles with `pix_ce` high. A line lasts `h_total_m1`+1 ticks, and the first tick after `start` is position 0 of line 0.
- R2: A frame lasts `v_total_m1`+1 lines. The vertical strobe is active on lines 0 to `v_sync_m1`.
- R3: The horizontal strobe is active at line positions `hs_pos` to `hs_pos`+`h_sync_m1`.
- R4: When `hs_porch_en` is 0, the horizontal strobe is suppressed on every line outside the visible rows. When it is 1, the strobe appears on every line.
- R5: DE is active only when the line position is in `h_front_m1`+1 to `h_front_m1`+1+`h_act_m1` and the line number is in `v_front_m1`+1 to `v_front_m1`+1+`v_act_m1`.
- R6: While DE is active, `pix_x` and `pix_y` give the offsets from the first visible column and the first visible row. Otherwise both are 0.
- R7: Each of `hsync`, `vsync` and `de` equals its idle-level input when inactive and the inverse of that input when active. All three are inactive while the generator is stopped.
- R8: A delay select of n (0 to 3) on `dly_hs`, `dly_vs` or `dly_de` delays that strobe by n pixel ticks. `data_req` is the active-high DE condition delayed by `dly_data` ticks.
- R9: With `next_frame_en` at 0 the generator stops after one frame. With it at 1, frames repeat back to back. A `start` while running has no effect.
- R10: `stop` takes effect at the end of the current frame, even when it arrives on the frame's last tick. After that all outputs return to their idle state.
- R11: `vsync_end_irq` pulses high for one clock in the cycle after the tick that ends line `v_sync_m1`.
- R12: After reset the generator is stopped, `pix_x`, `pix_y`, `data_req` and `vsync_end_irq` are 0, and the strobes sit at their idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_ce | input | 1 | Pixel tick enable |
| start | input | 1 | Start pulse, used while stopped |
| stop | input | 1 | Stop request, honoured at frame end |
| next_frame_en | input | 1 | Repeat frames back to back |
| hs_porch_en | input | 1 | Keep the horizontal strobe on non-visible lines |
| idle_hs | input | 1 | Idle level of hsync |
| idle_vs | input | 1 | Idle level of vsync |
| idle_de | input | 1 | Idle level of de |
| h_sync_m1 | input | CW | Horizontal sync width − 1 |
| h_front_m1 | input | CW | Horizontal sync + back porch − 1 |
| h_act_m1 | input | CW | Visible width − 1 |
| h_total_m1 | input | CW | Line length − 1 |
| hs_pos | input | CW | Start position of the horizontal strobe |
| v_sync_m1 | input | CW | Vertical sync lines − 1 |
| v_front_m1 | input | CW | Vertical sync + back porch lines − 1 |
| v_act_m1 | input | CW | Visible rows − 1 |
| v_total_m1 | input | CW | Frame lines − 1 |
| dly_hs | input | 2 | hsync delay in ticks |
| dly_vs | input | 2 | vsync delay in ticks |
| dly_de | input | 2 | de delay in ticks |
| dly_data | input | 2 | data_req delay in ticks |
| hsync | output | 1 | Horizontal strobe |
| vsync | output | 1 | Vertical strobe |
| de | output | 1 | Data enable |
| data_req | output | 1 | Pixel data request, active high |
| pix_x | output | CW | Visible column |
| pix_y | output | CW | Visible row |
| vsync_end_irq | output | 1 | End-of-vertical-sync pulse |

## Verification
A stop request can arrive on the same tick that closes the frame. The frame-end decision and the capture of the stop then fall in one cycle, and the stop must not slip to the next frame. The bench watches its own position model and drives `stop` for exactly that last tick of a repeating run. It judges the result by demanding that the outputs go idle right after that frame and that only one end-of-sync pulse appears. A second run pulses stop mid-frame in a repeating sequence and expects the frame to finish first.

// File: rtl/tg_pkg.sv
// Shared constants of the timing generator: indices of the delayed strobes.
// Assumes nothing beyond the four strobes listed here.
package tg_pkg;
    localparam int NSIG   = 4;
    localparam int SIG_HS = 0;
    localparam int SIG_VS = 1;
    localparam int SIG_DE = 2;
    localparam int SIG_DQ = 3;
endpackage

// File: rtl/tg_axis.sv
// One timing axis: a wrapping counter plus sync and visible-window decode.
// Assumes the endpoint inputs stay stable while the counter runs.
module tg_axis #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [CW-1:0] total_m1,
    input  logic [CW-1:0] sync_base,
    input  logic [CW-1:0] sync_m1,
    input  logic [CW-1:0] front_m1,
    input  logic [CW-1:0] act_m1,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          in_sync,
    output logic          in_act,
    output logic [CW-1:0] rel
);
    logic [CW-1:0] act_off;

    // Last position of the period reached on an advancing tick.
    assign wrap = adv && (cnt == total_m1);

    // Position counter: cleared at launch, wraps at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= wrap ? '0 : cnt + CW'(1);
        end
    end

    // Window decode for sync and visible span.
    always_comb begin
        act_off = cnt - front_m1 - CW'(1);
        in_sync = (cnt >= sync_base) && ((cnt - sync_base) <= sync_m1);
        in_act  = (cnt > front_m1) && (act_off <= act_m1);
        rel     = in_act ? act_off : '0;
    end
endmodule

// File: rtl/tg_delay.sv
// Selectable delay of one strobe by 0..TAPS pixel ticks.
// Assumes the select fits TAPS; the line shifts on every pixel tick.
module tg_delay #(
    parameter int TAPS = 3,
    localparam int SW  = $clog2(TAPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [SW-1:0] sel,
    input  logic          din,
    output logic          dout
);
    logic [TAPS-1:0] sr;

    // Shift chain advanced by the pixel tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (ce) begin
            sr <= {sr[TAPS-2:0], din};
        end
    end

    // Tap select; zero passes the input straight through.
    always_comb begin
        dout = din;
        for (int k = 0; k < TAPS; k++) begin
            if (sel == SW'(k + 1)) dout = sr[k];
        end
    end
endmodule

// File: rtl/rgb_timing_gen.sv
// RGB panel timing generator: sync/DE strobes, coordinates, data request
// and end-of-vsync pulse. Assumes timing inputs are stable while running.
module rgb_timing_gen
    import tg_pkg::*;
#(
    parameter int CW       = 12,
    parameter int DLY_TAPS = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pix_ce,
    input  logic                            start,
    input  logic                            stop,
    input  logic                            next_frame_en,
    input  logic                            hs_porch_en,
    input  logic                            idle_hs,
    input  logic                            idle_vs,
    input  logic                            idle_de,
    input  logic [CW-1:0]                   h_sync_m1,
    input  logic [CW-1:0]                   h_front_m1,
    input  logic [CW-1:0]                   h_act_m1,
    input  logic [CW-1:0]                   h_total_m1,
    input  logic [CW-1:0]                   hs_pos,
    input  logic [CW-1:0]                   v_sync_m1,
    input  logic [CW-1:0]                   v_front_m1,
    input  logic [CW-1:0]                   v_act_m1,
    input  logic [CW-1:0]                   v_total_m1,
    input  logic [$clog2(DLY_TAPS+1)-1:0]   dly_hs,
    input  logic [$clog2(DLY_TAPS+1)-1:0]   dly_vs,
    input  logic [$clog2(DLY_TAPS+1)-1:0]   dly_de,
    input  logic [$clog2(DLY_TAPS+1)-1:0]   dly_data,
    output logic                            hsync,
    output logic                            vsync,
    output logic                            de,
    output logic                            data_req,
    output logic [CW-1:0]                   pix_x,
    output logic [CW-1:0]                   pix_y,
    output logic                            vsync_end_irq
);
    localparam int DW = $clog2(DLY_TAPS + 1);

    logic          run_q, stop_pend_q, launch;
    logic [CW-1:0] hcnt, vcnt, h_rel, v_rel;
    logic          h_wrap, v_wrap, h_sync_w, v_sync_w, h_act_w, v_act_w;
    logic          frame_end, hs_raw, vs_raw, de_raw;
    logic [NSIG-1:0] raw_v, dly_v;
    logic [DW-1:0]   sel_v [NSIG];

    assign launch    = start && !run_q;
    assign frame_end = h_wrap && v_wrap;

    tg_axis #(.CW(CW)) h_axis_i (
        .clk(clk), .rst_n(rst_n), .clr(launch), .adv(run_q && pix_ce),
        .total_m1(h_total_m1), .sync_base(hs_pos), .sync_m1(h_sync_m1),
        .front_m1(h_front_m1), .act_m1(h_act_m1), .cnt(hcnt), .wrap(h_wrap),
        .in_sync(h_sync_w), .in_act(h_act_w), .rel(h_rel)
    );

    tg_axis #(.CW(CW)) v_axis_i (
        .clk(clk), .rst_n(rst_n), .clr(launch), .adv(h_wrap),
        .total_m1(v_total_m1), .sync_base('0), .sync_m1(v_sync_m1),
        .front_m1(v_front_m1), .act_m1(v_act_m1), .cnt(vcnt), .wrap(v_wrap),
        .in_sync(v_sync_w), .in_act(v_act_w), .rel(v_rel)
    );

    // Run state: launch while stopped, end at a frame boundary on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q       <= 1'b0;
            stop_pend_q <= 1'b0;
        end else if (!run_q) begin
            stop_pend_q <= 1'b0;
            run_q       <= start;
        end else if (frame_end) begin
            run_q       <= next_frame_en && !stop && !stop_pend_q;
            stop_pend_q <= 1'b0;
        end else if (stop) begin
            stop_pend_q <= 1'b1;
        end
    end

    // End-of-vertical-sync pulse, one clock after the closing tick.
    always_ff @(posedge clk) begin
        if (!rst_n) vsync_end_irq <= 1'b0;
        else        vsync_end_irq <= h_wrap && (vcnt == v_sync_m1);
    end

    // Undelayed active-high strobes and coordinates.
    always_comb begin
        hs_raw = run_q && h_sync_w && (v_act_w || hs_porch_en);
        vs_raw = run_q && v_sync_w;
        de_raw = run_q && h_act_w && v_act_w;
        pix_x  = de_raw ? h_rel : '0;
        pix_y  = de_raw ? v_rel : '0;
    end

    assign raw_v[SIG_HS] = hs_raw;
    assign raw_v[SIG_VS] = vs_raw;
    assign raw_v[SIG_DE] = de_raw;
    assign raw_v[SIG_DQ] = de_raw;
    assign sel_v[SIG_HS] = dly_hs;
    assign sel_v[SIG_VS] = dly_vs;
    assign sel_v[SIG_DE] = dly_de;
    assign sel_v[SIG_DQ] = dly_data;

    for (genvar g = 0; g < NSIG; g++) begin : g_dly
        tg_delay #(.TAPS(DLY_TAPS)) dly_i (
            .clk(clk), .rst_n(rst_n), .ce(pix_ce), .sel(sel_v[g]),
            .din(raw_v[g]), .dout(dly_v[g])
        );
    end

    assign hsync    = idle_hs ^ dly_v[SIG_HS];
    assign vsync    = idle_vs ^ dly_v[SIG_VS];
    assign de       = idle_de ^ dly_v[SIG_DE];
    assign data_req = dly_v[SIG_DQ];
endmodule

// File: rtl/tg_checker.sv
// Temporal checks on the timing generator, attached through bind.
// Assumes timing inputs are held stable while a frame runs.
module tg_checker #(
    parameter int CW       = 12,
    parameter int DLY_TAPS = 3
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          run,
    input logic                          pix_ce,
    input logic [CW-1:0]                 hcnt,
    input logic [CW-1:0]                 vcnt,
    input logic [CW-1:0]                 h_total_m1,
    input logic [CW-1:0]                 v_total_m1,
    input logic [CW-1:0]                 v_sync_m1,
    input logic                          irq,
    input logic                          vsync,
    input logic                          idle_vs,
    input logic [$clog2(DLY_TAPS+1)-1:0] dly_vs
);
    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !pix_ce) |=> ($stable(hcnt) && $stable(vcnt)));

    assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hcnt <= h_total_m1 && vcnt <= v_total_m1));

    assert_idle_vsync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && dly_vs == '0) |-> (vsync == idle_vs));

    assert_stop_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($past(hcnt) == $past(h_total_m1) && $past(vcnt) == $past(v_total_m1)));

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_irq_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(run) && $past(vcnt) == $past(v_sync_m1)));
endmodule

bind rgb_timing_gen tg_checker #(.CW(CW), .DLY_TAPS(DLY_TAPS)) tg_checker_i (
    .clk(clk), .rst_n(rst_n), .run(run_q), .pix_ce(pix_ce), .hcnt(hcnt),
    .vcnt(vcnt), .h_total_m1(h_total_m1), .v_total_m1(v_total_m1),
    .v_sync_m1(v_sync_m1), .irq(vsync_end_irq), .vsync(vsync),
    .idle_vs(idle_vs), .dly_vs(dly_vs)
);

// File: tb/rgb_timing_gen_tb_top.sv
// Self-checking bench: table of frame configurations, then directed tests.
module rgb_timing_gen_tb_top;
    localparam int CW = 12;

    typedef struct packed {
        logic [7:0] hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, hpos, porch;
        logic [7:0] dh, dv, dd, dq, ih, iv, ide, gap, exp_de;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{8'd2,8'd1,8'd4,8'd1, 8'd1,8'd1,8'd3,8'd1, 8'd0,8'd0, 8'd0,8'd0,8'd0,8'd0, 8'd0,8'd0,8'd0, 8'd0, 8'd12},
        '{8'd1,8'd2,8'd3,8'd2, 8'd2,8'd1,8'd2,8'd1, 8'd3,8'd1, 8'd1,8'd2,8'd3,8'd1, 8'd1,8'd1,8'd0, 8'd0, 8'd6},
        '{8'd3,8'd1,8'd5,8'd2, 8'd1,8'd2,8'd2,8'd2, 8'd1,8'd1, 8'd0,8'd0,8'd0,8'd0, 8'd0,8'd1,8'd1, 8'd1, 8'd20},
        '{8'd1,8'd0,8'd2,8'd0, 8'd1,8'd0,8'd2,8'd0, 8'd0,8'd0, 8'd3,8'd3,8'd0,8'd2, 8'd0,8'd0,8'd0, 8'd0, 8'd4},
        '{8'd2,8'd2,8'd6,8'd3, 8'd3,8'd1,8'd4,8'd2, 8'd5,8'd0, 8'd2,8'd1,8'd2,8'd3, 8'd1,8'd0,8'd1, 8'd1, 8'd48}
    };

    logic clk = 1'b0, rst_n = 1'b0, pix_ce = 1'b1, start = 1'b0, stop = 1'b0;
    logic next_frame_en = 1'b0, hs_porch_en = 1'b0;
    logic idle_hs = 1'b0, idle_vs = 1'b0, idle_de = 1'b0;
    logic [CW-1:0] h_sync_m1, h_front_m1, h_act_m1, h_total_m1, hs_pos;
    logic [CW-1:0] v_sync_m1, v_front_m1, v_act_m1, v_total_m1;
    logic [1:0] dly_hs = '0, dly_vs = '0, dly_de = '0, dly_data = '0;
    logic hsync, vsync, de, data_req, vsync_end_irq;
    logic [CW-1:0] pix_x, pix_y;

    int n_cmp = 0, n_bad = 0;
    int hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, hpos, porch, dh, dv, dd, dq, gap;
    int bx = 0, by = 0, de_cnt = 0, irq_cnt = 0;
    bit brun = 0, bpend = 0, exp_irq = 0;
    bit hh [3], vh [3], dh_h [3];

    always #10 clk = ~clk;

    rgb_timing_gen #(.CW(CW), .DLY_TAPS(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .start(start), .stop(stop),
        .next_frame_en(next_frame_en), .hs_porch_en(hs_porch_en),
        .idle_hs(idle_hs), .idle_vs(idle_vs), .idle_de(idle_de),
        .h_sync_m1(h_sync_m1), .h_front_m1(h_front_m1), .h_act_m1(h_act_m1),
        .h_total_m1(h_total_m1), .hs_pos(hs_pos), .v_sync_m1(v_sync_m1),
        .v_front_m1(v_front_m1), .v_act_m1(v_act_m1), .v_total_m1(v_total_m1),
        .dly_hs(dly_hs), .dly_vs(dly_vs), .dly_de(dly_de), .dly_data(dly_data),
        .hsync(hsync), .vsync(vsync), .de(de), .data_req(data_req),
        .pix_x(pix_x), .pix_y(pix_y), .vsync_end_irq(vsync_end_irq)
    );

    task automatic chk(input int act, input int exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference strobes for the model's current position.
    function automatic void calc(output bit hs, output bit vs, output bit dv_o,
                                 output int x, output int y);
        bit vin, hin;
        vin  = (by >= vsw + vbp) && (by < vsw + vbp + vact);
        hin  = (bx >= hsw + hbp) && (bx < hsw + hbp + hact);
        hs   = brun && (bx >= hpos) && (bx < hpos + hsw) && (vin || porch != 0);
        vs   = brun && (by < vsw);
        dv_o = brun && hin && vin;
        x    = dv_o ? bx - (hsw + hbp) : 0;
        y    = dv_o ? by - (vsw + vbp) : 0;
    endfunction

    task automatic apply(input vec_t v);
        hsw = int'(v.hsw); hbp = int'(v.hbp); hact = int'(v.hact); hfp = int'(v.hfp);
        vsw = int'(v.vsw); vbp = int'(v.vbp); vact = int'(v.vact); vfp = int'(v.vfp);
        hpos = int'(v.hpos); porch = int'(v.porch); gap = int'(v.gap);
        dh = int'(v.dh); dv = int'(v.dv); dd = int'(v.dd); dq = int'(v.dq);
        h_sync_m1  = CW'(hsw - 1);
        h_front_m1 = CW'(hsw + hbp - 1);
        h_act_m1   = CW'(hact - 1);
        h_total_m1 = CW'(hsw + hbp + hact + hfp - 1);
        hs_pos     = CW'(hpos);
        v_sync_m1  = CW'(vsw - 1);
        v_front_m1 = CW'(vsw + vbp - 1);
        v_act_m1   = CW'(vact - 1);
        v_total_m1 = CW'(vsw + vbp + vact + vfp - 1);
        hs_porch_en = (porch != 0);
        dly_hs = 2'(dh); dly_vs = 2'(dv); dly_de = 2'(dd); dly_data = 2'(dq);
        idle_hs = v.ih[0]; idle_vs = v.iv[0]; idle_de = v.ide[0];
    endtask

    // One clock: drive at negedge, advance the model at the edge, compare after.
    task automatic tick(input bit st, input bit sp);
        bit hs, vs, dvv, fe;
        int x, y, ht, vt;
        pix_ce = (gap != 0) ? ~pix_ce : 1'b1;
        start = st; stop = sp;
        @(posedge clk);
        ht = hsw + hbp + hact + hfp; vt = vsw + vbp + vact + vfp;
        calc(hs, vs, dvv, x, y);
        exp_irq = brun && pix_ce && (bx == ht - 1) && (by == vsw - 1);
        fe = brun && pix_ce && (bx == ht - 1) && (by == vt - 1);
        if (pix_ce) begin
            hh[2] = hh[1]; hh[1] = hh[0]; hh[0] = hs;
            vh[2] = vh[1]; vh[1] = vh[0]; vh[0] = vs;
            dh_h[2] = dh_h[1]; dh_h[1] = dh_h[0]; dh_h[0] = dvv;
        end
        if (!brun) begin
            bpend = 0;
            if (st) begin brun = 1; bx = 0; by = 0; end
        end else begin
            if (pix_ce) begin
                if (bx == ht - 1) begin bx = 0; by = (by == vt - 1) ? 0 : by + 1; end
                else bx++;
            end
            if (fe) begin
                if (sp || bpend || next_frame_en == 1'b0) brun = 0;
                bpend = 0;
            end else if (sp) bpend = 1;
        end
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        calc(hs, vs, dvv, x, y);
        chk(int'(hsync), int'(idle_hs ^ ((dh == 0) ? hs : hh[dh-1])), "R3 R4 R8 hsync");
        chk(int'(vsync), int'(idle_vs ^ ((dv == 0) ? vs : vh[dv-1])), "R2 R8 vsync");
        chk(int'(de), int'(idle_de ^ ((dd == 0) ? dvv : dh_h[dd-1])), "R5 R7 de");
        chk(int'(data_req), int'((dq == 0) ? dvv : dh_h[dq-1]), "R8 data_req");
        chk(int'(pix_x), x, "R1 R6 pix_x");
        chk(int'(pix_y), y, "R6 pix_y");
        chk(int'(vsync_end_irq), int'(exp_irq), "R11 vsync_end_irq");
        if (de != idle_de) de_cnt++;
        if (vsync_end_irq) irq_cnt++;
    endtask

    task automatic drain();
        while (brun) tick(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin : main
        apply(VEC[0]);
        idle_hs = 1'b1; idle_vs = 1'b0; idle_de = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state, R7 idle levels
        chk(int'(hsync), 1, "R12 R7 reset hsync");
        chk(int'(vsync), 0, "R12 R7 reset vsync");
        chk(int'(de), 1, "R12 R7 reset de");
        chk(int'(data_req), 0, "R12 reset data_req");
        chk(int'(pix_x) + int'(pix_y), 0, "R12 reset coords");
        chk(int'(vsync_end_irq), 0, "R12 reset irq");

        // Table walk: one single frame per entry (R1..R8, R9 single mode, R11)
        for (int t = 0; t < 5; t++) begin
            apply(VEC[t]);
            next_frame_en = 1'b0;
            for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
            de_cnt = 0; irq_cnt = 0;
            tick(1'b1, 1'b0);
            drain();
            chk(de_cnt, int'(VEC[t].exp_de), "R5 DE cycles per frame");
            chk(irq_cnt, 1, "R9 R11 single frame irq count");
            chk(int'(de), int'(idle_de), "R9 de idle after frame");
        end

        // R9 repeat with an ignored mid-run start, then a mid-frame stop (R10)
        apply(VEC[1]);
        next_frame_en = 1'b1;
        de_cnt = 0; irq_cnt = 0;
        tick(1'b1, 1'b0);
        for (int i = 0; i < 100; i++) tick(i == 60, i == 99);
        drain();
        chk(irq_cnt, 3, "R9 R10 repeated frames irq count");
        chk(de_cnt, 18, "R9 repeated frames DE cycles");

        // R10 stop arriving on the last tick of the frame
        apply(VEC[0]);
        next_frame_en = 1'b1;
        de_cnt = 0; irq_cnt = 0;
        tick(1'b1, 1'b0);
        while (brun) tick(1'b0, (bx == 7 && by == 5));
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0);
        chk(irq_cnt, 1, "R10 stop on last tick ends frame");
        chk(de_cnt, 12, "R10 stop on last tick DE cycles");
        chk(int'(vsync), int'(idle_vs), "R10 vsync idle after stop");
        chk(int'(hsync), int'(idle_hs), "R10 hsync idle after stop");

        // R10 stop while idle is ignored: next single frame still full
        next_frame_en = 1'b0;
        tick(1'b0, 1'b1);
        de_cnt = 0;
        tick(1'b1, 1'b0);
        drain();
        chk(de_cnt, 12, "R10 idle stop ignored");
        finish_run();
    end
endmodule